// File: doc/BRIEF.md
# Linear-Probing Region Table Walker

This block turns a 16-bit region identifier into the base virtual address of that region. It searches an open-addressed hash table that system software keeps in memory. When a walk is accepted, the identifier is folded into a starting slot. The block then reads table entries through a single read port, one slot after another, and stops on one of three conditions: a slot whose key matches, an empty slot, or a full sweep of the table. The outcome goes out as a one-cycle result pulse. The pulse carries either the base address or a fault, together with the identifier that was searched for.

A lookaside buffer sits in front of this block and starts a walk when it misses. The table base address comes in as a port and is captured at the moment a walk is accepted. The memory side is a valid/ready request channel and a response strobe with any latency. Only one read is outstanding at a time.

Top module: `regionTableWalker`

## Requirements
- R1: After reset, `reqReady` is 1, `memReqValid` is 0 and `resValid` is 0.
- R2: Slot i of the table is read at byte address `tableBase + 16*i`. Every read address is 16-byte aligned and lies below `tableBase + 16*2^IDX_W`. An entry is 128 bits: bit 0 is the valid flag, bits [31:16] hold the key and bits [127:64] hold the base address.
- R3: The first slot read is the XOR fold of the identifier. Index bit j is the XOR of every identifier bit k for which k mod IDX_W equals j.
- R4: If the slot read holds a valid entry whose key equals the identifier, the walk ends. The result then has `resFault`=0, `resBase` equal to that entry's base address, and `resId` equal to the identifier.
- R5: If the slot read has valid flag 0, the walk ends with `resFault`=1 and `resBase`=0.
- R6: Each further probe reads the next slot, index plus one, and the index wraps from 2^IDX_W-1 to 0.
- R7: A walk ends after at most 2^IDX_W probes. If the last probe neither matches nor finds an empty slot, the result is a fault. A match on that last probe is still a hit.
- R8: Only one read is outstanding at a time. While `memReqValid` waits for `memReqReady`, the request stays asserted and its address does not change. `memRspValid` is ignored unless a read is outstanding.
- R9: A walk is accepted only while `reqReady` is 1, and `reqReady` drops in the cycle after acceptance. A `reqValid` during a walk is ignored. `resValid` is a one-cycle pulse, and `reqReady` is 1 during that pulse.
- R10: `reqId` and `tableBase` are captured when a walk is accepted. Changes on those ports during the walk have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Walk request strobe |
| reqReady | output | 1 | Block idle, request can be taken |
| reqId | input | ID_W | Region identifier to resolve |
| tableBase | input | ADDR_W | Byte address of table slot 0 |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Memory takes the read request |
| memReqAddr | output | ADDR_W | Byte address of the slot to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 128 | Table entry read |
| resValid | output | 1 | Result pulse |
| resFault | output | 1 | Invalid region (empty slot or table exhausted) |
| resBase | output | ADDR_W | Base address on a hit, zero on a fault |
| resId | output | ID_W | Identifier the result belongs to |

## Verification
The bench builds the walker with IDX_W=6, so the table has 64 slots. At that size the wrap from the last slot to slot 0 shows up with only a few colliding keys, and a full sweep of the table without a match or an empty slot takes only a few hundred cycles. The other parameters keep their defaults, so identifiers stay 16 bits wide. That width makes the fold XOR three chunks together, and the collision keys used in the bench are chosen to exercise that.

// File: rtl/walkerPkg.sv
package walkerPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture request, set start index
    logic step;    // advance to next slot
    logic finish;  // capture result and pulse
  } walkCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walkState_t;

  // Entry layout (128-bit slots)
  localparam int ENTRY_W     = 128;
  localparam int ENTRY_SHIFT = 4;   // log2 of 16 bytes per slot
  localparam int VALID_BIT   = 0;
  localparam int KEY_LO      = 16;
  localparam int BASE_LO     = 64;

endpackage

// File: rtl/walkerDatapath.sv
module walkerDatapath
  import walkerPkg::*;
#(
  parameter int ID_W   = 16,
  parameter int IDX_W  = 14,
  parameter int ADDR_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  walkCtl_t            ctl,
  input  logic [ID_W-1:0]     reqId,
  input  logic [ADDR_W-1:0]   tableBase,
  input  logic [ENTRY_W-1:0]  memRspData,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic                entryEmpty,
  output logic                entryMatch,
  output logic                lastProbe,
  output logic                resValid,
  output logic                resFault,
  output logic [ADDR_W-1:0]   resBase,
  output logic [ID_W-1:0]     resId
);

  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'((2 ** IDX_W) - 1);
  localparam logic [ADDR_W-1:0] TABLE_BYTES = ADDR_W'((2 ** IDX_W) * 16);

  // Fold the identifier down to an index by XOR
  function automatic logic [IDX_W-1:0] foldId(input logic [ID_W-1:0] id);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int b = 0; b < ID_W; b++) begin
      h[b % IDX_W] = h[b % IDX_W] ^ id[b];
    end
    return h;
  endfunction

  logic [ID_W-1:0]   idReg;
  logic [ADDR_W-1:0] baseReg;
  logic [IDX_W-1:0]  idxReg;
  logic [CNT_W-1:0]  cntReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg   <= '0;
      baseReg <= '0;
      idxReg  <= '0;
      cntReg  <= '0;
    end else if (ctl.load) begin
      idReg   <= reqId;
      baseReg <= tableBase;
      idxReg  <= foldId(reqId);
      cntReg  <= '0;
    end else if (ctl.step) begin
      idxReg  <= idxReg + 1'b1;  // wraps modulo table size
      cntReg  <= cntReg + 1'b1;
    end
  end

  assign memReqAddr = baseReg + (ADDR_W'(idxReg) << ENTRY_SHIFT);

  // Entry decode
  logic              entryValid;
  logic [ID_W-1:0]   entryKey;
  logic [ADDR_W-1:0] entryBase;

  assign entryValid = memRspData[VALID_BIT];
  assign entryKey   = memRspData[KEY_LO +: ID_W];
  assign entryBase  = memRspData[BASE_LO +: ADDR_W];
  assign entryEmpty = !entryValid;
  assign entryMatch = entryValid && (entryKey == idReg);
  assign lastProbe  = (cntReg == LAST_CNT);

  // Result register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resFault <= 1'b0;
      resBase  <= '0;
      resId    <= '0;
    end else begin
      resValid <= ctl.finish;
      if (ctl.finish) begin
        resFault <= !entryMatch;
        resBase  <= entryMatch ? entryBase : '0;
        resId    <= idReg;
      end
    end
  end

  // R2: read address inside table and slot aligned
  p_addr_in_table_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((memReqAddr - baseReg) < TABLE_BYTES) && (memReqAddr[ENTRY_SHIFT-1:0] == baseReg[ENTRY_SHIFT-1:0]));

  // R7: control never steps past the last probe
  p_walk_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> (cntReg != LAST_CNT));

  // R5: a fault never carries a base address
  p_fault_zero_base_r5: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resFault) |-> (resBase == '0));

  // R10: captured identifier and base stay fixed while probing
  p_capture_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> ($stable(baseReg) && $stable(idReg)));

endmodule

// File: rtl/walkerControl.sv
module walkerControl
  import walkerPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  output logic     reqReady,
  output logic     memReqValid,
  input  logic     memReqReady,
  input  logic     memRspValid,
  input  logic     entryEmpty,
  input  logic     entryMatch,
  input  logic     lastProbe,
  output walkCtl_t ctl
);

  walkState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.load  = 1'b1;
          stateNext = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (memReqReady) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          if (entryEmpty || entryMatch || lastProbe) begin
            ctl.finish = 1'b1;
            stateNext  = ST_IDLE;
          end else begin
            ctl.step  = 1'b1;
            stateNext = ST_ISSUE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_ISSUE);

  // R9: an accepted walk makes the block busy next cycle
  p_accept_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R8: no new read issued while one is awaited
  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid);

endmodule

// File: rtl/regionTableWalker.sv
module regionTableWalker
  import walkerPkg::*;
#(
  parameter int ID_W   = 16,
  parameter int IDX_W  = 14,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ID_W-1:0]   reqId,
  input  logic [ADDR_W-1:0] tableBase,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [127:0]      memRspData,
  output logic              resValid,
  output logic              resFault,
  output logic [ADDR_W-1:0] resBase,
  output logic [ID_W-1:0]   resId
);

  walkCtl_t ctl;
  logic     entryEmpty, entryMatch, lastProbe;

  walkerControl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .entryEmpty  (entryEmpty),
    .entryMatch  (entryMatch),
    .lastProbe   (lastProbe),
    .ctl         (ctl)
  );

  walkerDatapath #(
    .ID_W   (ID_W),
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqId      (reqId),
    .tableBase  (tableBase),
    .memRspData (memRspData),
    .memReqAddr (memReqAddr),
    .entryEmpty (entryEmpty),
    .entryMatch (entryMatch),
    .lastProbe  (lastProbe),
    .resValid   (resValid),
    .resFault   (resFault),
    .resBase    (resBase),
    .resId      (resId)
  );

  // R8: stalled request held with a stable address
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  // R9: result is a single-cycle pulse
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

endmodule

// File: tb/regionTableWalker_test.sv
module regionTableWalker_test;

  localparam int ID_W   = 16;
  localparam int IDX_W  = 6;
  localparam int ADDR_W = 64;
  localparam int NSLOT  = 2 ** IDX_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ID_W-1:0]   reqId = '0;
  logic [ADDR_W-1:0] tableBase = '0;
  logic              memReqValid;
  logic              memReqReady = 1'b0;
  logic [ADDR_W-1:0] memReqAddr;
  logic              memRspValid = 1'b0;
  logic [127:0]      memRspData = '0;
  logic              resValid;
  logic              resFault;
  logic [ADDR_W-1:0] resBase;
  logic [ID_W-1:0]   resId;

  always #2.5 clk = ~clk;  // 200 MHz

  regionTableWalker #(.ID_W(ID_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqId(reqId), .tableBase(tableBase),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .resValid(resValid), .resFault(resFault), .resBase(resBase), .resId(resId)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic              fault;
    logic [ADDR_W-1:0] base;
    logic [ID_W-1:0]   id;
    string             tag;
  } expItem_t;

  expItem_t expQ[$];
  logic [127:0] mem [NSLOT];

  // model state
  logic [ADDR_W-1:0] curBase = '0;
  int                expIdx = 0;
  bit                firstProbe = 0;
  bit                pending = 0;
  int                lat = 0;
  int                pIdx = 0;
  bit                stallPrev = 0;
  logic [ADDR_W-1:0] stallAddr = '0;
  logic [15:0]       lfsr = 16'hACE1;

  function automatic int hashRef(input logic [ID_W-1:0] id);
    int h = 0;
    for (int b = 0; b < ID_W; b++) if (id[b]) h = h ^ (1 << (b % IDX_W));
    return h;
  endfunction

  function automatic logic [127:0] mkEntry(input bit v, input logic [15:0] key, input logic [63:0] base);
    logic [127:0] e = '0;
    e[0] = v;
    e[31:16] = key;
    e[127:64] = base;
    return e;
  endfunction

  task automatic clearMem();
    for (int i = 0; i < NSLOT; i++) mem[i] = '0;
  endtask

  task automatic insertRef(input logic [15:0] key, input logic [63:0] base);
    int idx = hashRef(key);
    for (int p = 0; p < NSLOT; p++) begin
      if (!mem[idx][0]) begin
        mem[idx] = mkEntry(1'b1, key, base);
        return;
      end
      idx = (idx + 1) % NSLOT;
    end
  endtask

  task automatic refLookup(input logic [15:0] id, output logic fault, output logic [63:0] base);
    int idx = hashRef(id);
    fault = 1'b1;
    base  = '0;
    for (int p = 0; p < NSLOT; p++) begin
      if (!mem[idx][0]) return;
      if (mem[idx][31:16] == id) begin
        fault = 1'b0;
        base  = mem[idx][127:64];
        return;
      end
      idx = (idx + 1) % NSLOT;
    end
  endtask

  // Driver: push expectation, issue request, optionally disturb the ports
  task automatic walk(input logic [15:0] id, input logic [63:0] tb, input bit disturb, input string tag);
    expItem_t e;
    logic f;
    logic [63:0] b;
    refLookup(id, f, b);
    e.fault = f; e.base = b; e.id = id; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    curBase    = tb;
    expIdx     = hashRef(id);
    firstProbe = 1;
    reqValid   = 1'b1;
    reqId      = id;
    tableBase  = tb;
    @(negedge clk);
    reqValid = 1'b0;
    checks++;
    if (reqReady !== 1'b0) begin
      fails++;
      $display("FAIL R9: reqReady after accept got %b expected 0", reqReady);
    end
    if (disturb) begin
      // R9/R10: request pins toggled during the walk must be ignored
      tableBase = ~tb;
      reqId     = id ^ 16'h5A5A;
      reqValid  = 1'b1;
      @(negedge clk);
      reqValid  = 1'b0;
    end
    while (expQ.size() != 0) @(negedge clk);
  endtask

  // Memory model with variable latency and stray responses
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      memRspValid = 1'b0;
      if (stallPrev) begin
        checks++;
        if (!(memReqValid === 1'b1 && memReqAddr === stallAddr)) begin
          fails++;
          $display("FAIL R8: stalled request got valid=%b addr=%h expected 1 addr=%h",
                   memReqValid, memReqAddr, stallAddr);
        end
      end
      stallPrev = 0;
      if (pending) begin
        memReqReady = 1'b0;
        if (lat == 0) begin
          memRspValid = 1'b1;
          memRspData  = mem[pIdx];
          pending     = 0;
        end else lat--;
      end else if (memReqValid) begin
        memReqReady = lfsr[0] | lfsr[1];
        if (memReqReady) begin
          logic [ADDR_W-1:0] off;
          int idx;
          off = memReqAddr - curBase;
          idx = int'(off[IDX_W+3:4]);
          checks++;
          if (off[3:0] != 4'd0 || off >= ADDR_W'(NSLOT * 16)) begin
            fails++;
            $display("FAIL R2: read address %h got offset %h expected aligned below %0d", memReqAddr, off, NSLOT * 16);
          end else if (idx != expIdx) begin
            fails++;
            if (firstProbe) $display("FAIL R3: start slot got %0d expected %0d", idx, expIdx);
            else            $display("FAIL R6: next slot got %0d expected %0d", idx, expIdx);
          end
          firstProbe = 0;
          pIdx    = idx;
          expIdx  = (expIdx + 1) % NSLOT;
          pending = 1;
          lat     = int'(lfsr[3:2]) % 3;
        end else begin
          stallPrev = 1;
          stallAddr = memReqAddr;
          if (lfsr[4]) begin
            // R8: stray response while no read outstanding (an empty slot)
            memRspValid = 1'b1;
            memRspData  = '0;
          end
        end
      end else begin
        memReqReady = lfsr[5];
      end
    end
  end

  // Monitor: compare results against scoreboard
  bit prevRes = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (resValid === 1'b1) begin
        checks++;
        if (prevRes) begin
          fails++;
          $display("FAIL R9: resValid got two cycles expected one");
        end
        if (reqReady !== 1'b1) begin
          fails++;
          $display("FAIL R9: reqReady during result got %b expected 1", reqReady);
        end
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R9: unexpected result id=%h expected none", resId);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          if (resFault !== e.fault || resBase !== e.base || resId !== e.id) begin
            fails++;
            $display("FAIL %s: got fault=%b base=%h id=%h expected fault=%b base=%h id=%h",
                     e.tag, resFault, resBase, resId, e.fault, e.base, e.id);
          end
        end
      end
      prevRes = (resValid === 1'b1);
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, got no finish expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    clearMem();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (reqReady !== 1'b1 || memReqValid !== 1'b0 || resValid !== 1'b0) begin
      fails++;
      $display("FAIL R1: got ready=%b memValid=%b res=%b expected 1 0 0", reqReady, memReqValid, resValid);
    end

    // Collision cluster at slot 1 (keys with equal fold)
    insertRef(16'h0001, 64'h0000_7000_0000_1000);
    insertRef(16'h0040, 64'h0000_7000_0000_2000);
    insertRef(16'h1000, 64'h0000_7000_0000_3000);
    walk(16'h0001, 64'h0000_0040_0000_0000, 0, "R4");
    walk(16'h0040, 64'h0000_0040_0000_0000, 0, "R4");
    walk(16'h1000, 64'h0000_0040_0000_0000, 1, "R10");
    walk(16'h1041, 64'h0000_0040_0000_0000, 0, "R5");

    // Wrap around: cluster starting at slot 63
    insertRef(16'h003F, 64'h0000_7100_0000_0000);
    insertRef(16'h007E, 64'h0000_7100_0000_0010);
    insertRef(16'h103E, 64'h0000_7100_0000_0020);
    walk(16'h003F, 64'h0000_0050_0000_1000, 0, "R4");
    walk(16'h007E, 64'h0000_0050_0000_1000, 0, "R6");
    walk(16'h103E, 64'h0000_0050_0000_1000, 1, "R6");

    // Corner identifiers
    walk(16'h0000, 64'h0000_0060_0000_0000, 0, "R5");
    insertRef(16'h0000, 64'h0000_7200_0000_0000);
    insertRef(16'hFFFF, 64'hFFFF_FFFF_FFFF_F000);
    walk(16'h0000, 64'h0000_0060_0000_0000, 0, "R4");
    walk(16'hFFFF, 64'h0000_0060_0000_0000, 1, "R4");

    // Full table: exhaustion fault and hit on the last probe
    for (int i = 0; i < NSLOT; i++) mem[i] = mkEntry(1'b1, 16'h2000 + 16'(i * 3), 64'h0000_7300_0000_0000 + 64'(i));
    walk(16'h0BAD, 64'h0000_0070_0000_0000, 0, "R7");
    mem[(hashRef(16'h0BAD) + NSLOT - 1) % NSLOT] = mkEntry(1'b1, 16'h0BAD, 64'h0000_7400_0000_0ABC);
    walk(16'h0BAD, 64'h0000_0070_0000_0000, 1, "R7");

    repeat (5) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R9: pending results got %0d expected 0", expQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule